// File: doc/BRIEF.md
# Carry-Select Adder/Subtractor

This block adds or subtracts two unsigned 8-bit operands and reports the 8-bit result, the carry out of the top bit and a sign flag taken from the result's top bit. A divider's control uses the sign flag to pick its next step. Subtraction inverts the second operand bit by bit and injects a carry of one into the lowest position, which forms the two's complement.

The word is cut into nibble segments. The lowest segment is a single ripple chain of full-adder cells. Every higher segment holds two ripple chains. Both chains see the same operand bits, but one assumes an incoming carry of zero and the other an incoming carry of one. The carry leaving the segment below picks which chain's sum and carry are passed on. At the default width, this gives three 4-bit ripple adders and one selector.

The arithmetic is combinational. The sum, carry and sign are registered once at the output, so a result appears on the clock edge after its operands are applied. The register clears asynchronously on reset.

Top module: `csa_addsub_unit`

## Requirements
- R1: With op_sub = 0, after the next rising clock edge, {carry_o, res_o} equals the 9-bit sum op_a + op_b. carry_o is bit 8 and res_o is bits 7..0.
- R2: With op_sub = 1, after the next rising clock edge, res_o equals (op_a - op_b) mod 256. carry_o is 1 exactly when op_a >= op_b unsigned, meaning no borrow.
- R3: After every rising edge out of reset, neg_o equals bit 7 of res_o.
- R4: The outputs change only at a rising clock edge. A change of operands or op_sub in mid-cycle leaves res_o, carry_o and neg_o holding the previous result.
- R5: While rst_n is low, res_o, carry_o and neg_o are all 0. This takes effect without waiting for a clock edge.
- R6: Subtracting equal operands gives res_o = 0, carry_o = 1 and neg_o = 0. In this case the carry travels through every bit position.
- R7: A carry leaving bit 3 reaches the upper nibble. For example, 0x0F + 0x01 gives res_o = 0x10 and carry_o = 0.
- R8: An addition that overflows 8 bits wraps around and sets carry_o. For example, 0xFF + 0x01 gives res_o = 0x00 and carry_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low, that clears the output register |
| op_a | input | 8 | First operand (minuend when subtracting) |
| op_b | input | 8 | Second operand (subtrahend when subtracting) |
| op_sub | input | 1 | 0 selects addition, 1 selects subtraction |
| res_o | output | 8 | Registered sum or difference |
| carry_o | output | 1 | Registered carry out of bit 7 |
| neg_o | output | 1 | Registered bit 7 of the result, used as the sign flag |

## Verification
Each sum, carry and sign is due exactly one rising edge after its operands and op_sub are applied. The reset clear appears at once, with no edge needed. The bench changes inputs on the falling edge. It looks again one nanosecond later to confirm that the previous result is still held, then compares against its own behavioural model at the following falling edge. This places every comparison half a period away from the edge that updates the register. Stimulus covers chosen carry-chain cases, equal-operand subtraction over a range of values and a long run of pseudo-random operands in both modes.

// File: rtl/csa_pkg.sv
package csa_pkg;
    localparam int unsigned DEF_WIDTH = 8;
    localparam int unsigned DEF_SEG   = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } csa_op_e;
endpackage

// File: rtl/csa_fa_cell.sv
module csa_fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic p_w;
    assign p_w = a_i ^ b_i;
    assign s_o = p_w ^ c_i;
    assign c_o = (a_i & b_i) | (p_w & c_i);
endmodule

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         c_i,
    output logic [N-1:0] s_o,
    output logic         c_o
);
    logic [N:0] chain_w;
    assign chain_w[0] = c_i;

    for (genvar i = 0; i < N; i++) begin : g_bit
        csa_fa_cell u_fa (
            .a_i (a_i[i]),
            .b_i (b_i[i]),
            .c_i (chain_w[i]),
            .s_o (s_o[i]),
            .c_o (chain_w[i+1])
        );
    end

    assign c_o = chain_w[N];
endmodule

// File: rtl/csa_seg_mux.sv
module csa_seg_mux #(
    parameter int unsigned N = 4
) (
    input  logic         sel_i,
    input  logic [N-1:0] s0_i,
    input  logic         c0_i,
    input  logic [N-1:0] s1_i,
    input  logic         c1_i,
    output logic [N-1:0] s_o,
    output logic         c_o
);
    always_comb begin
        if (sel_i) begin
            s_o = s1_i;
            c_o = c1_i;
        end else begin
            s_o = s0_i;
            c_o = c0_i;
        end
    end
endmodule

// File: rtl/csa_select_core.sv
module csa_select_core #(
    parameter int unsigned W   = 8,
    parameter int unsigned SEG = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam int unsigned NSEG = W / SEG;

    logic [W-1:0]  b_x;
    logic [NSEG:0] seg_c;

    assign b_x      = b_i ^ {W{sub_i}};
    assign seg_c[0] = sub_i;

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        if (k == 0) begin : g_base
            csa_ripple #(.N(SEG)) u_low (
                .a_i (a_i[SEG-1:0]),
                .b_i (b_x[SEG-1:0]),
                .c_i (seg_c[0]),
                .s_o (sum_o[SEG-1:0]),
                .c_o (seg_c[1])
            );
        end else begin : g_pair
            logic [SEG-1:0] s_c0;
            logic [SEG-1:0] s_c1;
            logic           co_c0;
            logic           co_c1;

            csa_ripple #(.N(SEG)) u_cin0 (
                .a_i (a_i[k*SEG +: SEG]),
                .b_i (b_x[k*SEG +: SEG]),
                .c_i (1'b0),
                .s_o (s_c0),
                .c_o (co_c0)
            );

            csa_ripple #(.N(SEG)) u_cin1 (
                .a_i (a_i[k*SEG +: SEG]),
                .b_i (b_x[k*SEG +: SEG]),
                .c_i (1'b1),
                .s_o (s_c1),
                .c_o (co_c1)
            );

            csa_seg_mux #(.N(SEG)) u_pick (
                .sel_i (seg_c[k]),
                .s0_i  (s_c0),
                .c0_i  (co_c0),
                .s1_i  (s_c1),
                .c1_i  (co_c1),
                .s_o   (sum_o[k*SEG +: SEG]),
                .c_o   (seg_c[k+1])
            );
        end
    end

    assign cout_o = seg_c[NSEG];
endmodule

// File: rtl/csa_addsub_unit.sv
module csa_addsub_unit #(
    parameter int unsigned W   = csa_pkg::DEF_WIDTH,
    parameter int unsigned SEG = csa_pkg::DEF_SEG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         op_sub,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         neg_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         cout;
        logic         neg;
    } out_t;

    out_t         out_d;
    out_t         out_q;
    logic [W-1:0] core_sum;
    logic         core_cout;
    csa_pkg::csa_op_e op_mode;

    assign op_mode = csa_pkg::csa_op_e'(op_sub);

    csa_select_core #(.W(W), .SEG(SEG)) u_core (
        .a_i    (op_a),
        .b_i    (op_b),
        .sub_i  (op_mode == csa_pkg::OP_SUB),
        .sum_o  (core_sum),
        .cout_o (core_cout)
    );

    always_comb begin
        out_d      = out_q;
        out_d.res  = core_sum;
        out_d.cout = core_cout;
        out_d.neg  = core_sum[W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o   = out_q.res;
    assign carry_o = out_q.cout;
    assign neg_o   = out_q.neg;
endmodule

// File: rtl/csa_addsub_chk.sv
module csa_addsub_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         op_sub,
    input logic [W-1:0] res_o,
    input logic         carry_o,
    input logic         neg_o
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    p_add_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(op_sub)) |->
        ({carry_o, res_o} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

    // R2
    p_sub_diff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_sub)) |->
        ((res_o == W'($past(op_a) - $past(op_b))) &&
         (carry_o == ($past(op_a) >= $past(op_b)))));

    // R3
    p_sign_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (neg_o == res_o[W-1]));

    // R5
    p_reset_clear_r5: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !carry_o && !neg_o));

    // R6
    p_equal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_sub) && ($past(op_a) == $past(op_b))) |->
        (res_o == '0 && carry_o && !neg_o));
endmodule

bind csa_addsub_unit csa_addsub_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .op_sub  (op_sub),
    .res_o   (res_o),
    .carry_o (carry_o),
    .neg_o   (neg_o)
);

// File: tb/tb_csa_addsub_unit.sv
`timescale 1ns/1ps
module tb_csa_addsub_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = 8'hA5;
    logic [7:0] op_b = 8'h3C;
    logic       op_sub = 1'b0;
    logic [7:0] res_o;
    logic       carry_o;
    logic       neg_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int exp_q[$];
    int prev_exp = 0;

    always #2 clk = ~clk;

    csa_addsub_unit dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_a    (op_a),
        .op_b    (op_b),
        .op_sub  (op_sub),
        .res_o   (res_o),
        .carry_o (carry_o),
        .neg_o   (neg_o)
    );

    function automatic int model(input int a, input int b, input bit s);
        int tot;
        if (s) tot = a + (255 - b) + 1;
        else   tot = a + b;
        return tot & 9'h1FF;
    endfunction

    task automatic compare(input int expv, input string tag);
        int act;
        int eneg;
        act  = {23'd0, carry_o, res_o};
        eneg = (expv >> 7) & 1;
        checks++;
        if (act != expv || int'(neg_o) != eneg) begin
            errors++;
            $display("FAIL %s: got carry=%0d res=0x%02h neg=%0d, expected carry=%0d res=0x%02h neg=%0d",
                     tag, carry_o, res_o, neg_o, expv >> 8, expv & 255, eneg);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic run_op(input int a, input int b, input bit s, input string tag);
        exp_q.push_back(model(a, b, s));
        op_a   = 8'(a);
        op_b   = 8'(b);
        op_sub = s;
        #1;
        compare(prev_exp, "R4 hold");
        @(negedge clk);
        prev_exp = exp_q.pop_front();
        compare(prev_exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare(0, "R5 reset");
        rst_n = 1'b1;
        prev_exp = 0;

        run_op(8'h12, 8'h34, 1'b0, "R1 add");
        run_op(8'hF0, 8'h10, 1'b0, "R1 add carry");
        run_op(8'h0F, 8'h01, 1'b0, "R7 nibble carry");
        run_op(8'h7F, 8'h01, 1'b0, "R7 nibble carry to sign");
        run_op(8'hFF, 8'h01, 1'b0, "R8 wrap");
        run_op(8'hFF, 8'hFF, 1'b0, "R8 wrap");
        run_op(8'h05, 8'h05, 1'b1, "R6 equal sub");
        run_op(8'h00, 8'h01, 1'b1, "R2 borrow");
        run_op(8'hC8, 8'h64, 1'b1, "R2 sub");
        run_op(8'h10, 8'h01, 1'b1, "R2 nibble borrow");
        run_op(8'h00, 8'h00, 1'b1, "R6 equal zero");
        run_op(8'h80, 8'h00, 1'b0, "R3 sign");
        for (int v = 0; v < 256; v += 17) run_op(v, v, 1'b1, "R6 equal sweep");
        run_op(255, 255, 1'b1, "R6 equal max");

        for (int n = 0; n < 4000; n++) begin
            int ra;
            int rb;
            ra = int'($urandom_range(255, 0));
            rb = int'($urandom_range(255, 0));
            run_op(ra, rb, n[0], n[0] ? "R2 random sub" : "R1 random add");
        end

        run_op(8'h3A, 8'h91, 1'b0, "R3 sign add");
        rst_n = 1'b0;
        #1;
        compare(0, "R5 async reset");
        @(negedge clk);
        compare(0, "R5 reset held");
        rst_n = 1'b1;
        prev_exp = 0;
        run_op(8'h0F, 8'h0F, 1'b1, "R6 after reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule